// File: doc/BRIEF.md
# Micro-Op Cache Fill Eligibility Tracker

This block watches a stream of decoded instructions, each presented with the byte address where it starts and the number of micro-ops it decodes into. It groups the instructions into aligned 32-byte code windows, adds up the micro-ops charged to each window, and decides whether the window fits a micro-op cache. In that cache one window may use at most three ways, and each way holds at most six micro-ops. An instruction is charged to the window that holds its first byte, even when its last byte spills into the next window. Every micro-op counts toward the budget, including the single micro-op of a one-byte instruction that needs no execution unit.

A window is closed when an instruction from a different window arrives, or one cycle after an instruction flagged as the last of its run. The block then emits one record. For a window that fits, the record gives the number of ways used, the fill of each way (ways are filled in order, six micro-ops at a time, and the last way may be partly filled), and the number of cycles the cached window needs to deliver its micro-ops at the configured delivery width. For a window that exceeds eighteen micro-ops, the record raises a bypass flag instead: none of that window's code may be cached, and the legacy decoders must serve it.

Top module: `uc_fill_track`

## Requirements
- R1: The window index of an instruction is its start address with the low five bits dropped (`in_addr[31:5]`). The whole instruction is charged to that window, whatever its length.
- R2: The window total is the sum of `in_uops` over every instruction charged to the window. Instructions with one micro-op count one each, and zero-micro-op instructions add nothing.
- R3: When an instruction from a different window is accepted at a clock edge while a window is held, the held window's record is on the outputs in the cycle after that edge.
- R4: When an instruction with `in_last` set is accepted at edge t, its window's record is on the outputs in the cycle after edge t+1, and not in the cycle after edge t.
- R5: For a total T of at most 18, `rec_ways` = ceil(T/6). Way i (bits `rec_fill[3i+2:3i]`, way 0 in the low bits) holds min(6, max(0, T-6i)).
- R6: A total above 18 sets `rec_bypass` to 1 and forces `rec_ways`, `rec_fill` and `rec_beats` to 0. A total of exactly 18 is cacheable.
- R7: For a cacheable window, `rec_beats` = ceil(T/DLV_W), where `DLV_W` (6 by default, 4 in the narrow variant) is the number of micro-ops delivered per cycle.
- R8: A synchronous active-high `rst` discards any partly accumulated window without a record, and `rec_valid` is low in the cycle after a reset edge.
- R9: `rec_valid` is high for exactly one cycle per closed window and is low in every other cycle. All record fields are zero when `rec_valid` is low.
- R10: The window total saturates at 255 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_addr | input | 32 | Byte address where the instruction starts |
| in_uops | input | 3 | Micro-ops the instruction decodes into |
| in_last | input | 1 | Last instruction of the run; closes its window |
| rec_valid | output | 1 | A window record is presented this cycle |
| rec_window | output | 27 | Index of the closed window |
| rec_total | output | 8 | Micro-ops charged to the window (saturating) |
| rec_bypass | output | 1 | Window is over budget and must not be cached |
| rec_ways | output | 2 | Ways allocated |
| rec_fill | output | 9 | Micro-ops in each way, 3 bits per way, way 0 lowest |
| rec_beats | output | 3 | Delivery cycles for the cached window |

## Verification
A wrong accumulator state shows up at the ports as a wrong total, way count or bypass flag in the very next record. This happens within one cycle of the crossing, or two cycles after a last-marked instruction, so the bench compares each output against a behavioural model in every cycle. A held window that fails to close, or that closes twice, shows up as a `rec_valid` pulse in the wrong cycle. Such timing slips are caught by the cycle-exact comparison and by directed checks on crossing, flush, reset discard, an instruction that straddles a window boundary, the exact budget of 18 against 19, and total saturation.

// File: rtl/uc_pkg.sv
package uc_pkg;
    // Reason a held window is closed in a given cycle
    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_CROSS = 2'd1,
        CLS_FLUSH = 2'd2
    } close_e;
endpackage

// File: rtl/uc_window_acc.sv
module uc_window_acc #(
    parameter int WIN_W = 27,
    parameter int UOP_W = 3,
    parameter int TOT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_win,
    input  logic [UOP_W-1:0] in_uops,
    input  logic             in_last,
    output logic             close_o,
    output logic [WIN_W-1:0] close_win_o,
    output logic [TOT_W-1:0] close_total_o
);
    import uc_pkg::*;

    typedef struct packed {
        logic             open;
        logic             flush;
        logic [WIN_W-1:0] win;
        logic [TOT_W-1:0] total;
    } acc_t;

    acc_t   acc_d, acc_q;
    close_e cause;
    logic   same;
    logic [TOT_W:0] sum;

    always_comb begin
        acc_d = acc_q;
        same  = acc_q.open && !acc_q.flush && (in_win == acc_q.win);
        if (acc_q.open && acc_q.flush)
            cause = CLS_FLUSH;
        else if (acc_q.open && in_valid && (in_win != acc_q.win))
            cause = CLS_CROSS;
        else
            cause = CLS_NONE;
        sum = {1'b0, acc_q.total} + (TOT_W+1)'(in_uops);
        if (in_valid) begin
            if (same) begin
                acc_d.total = sum[TOT_W] ? '1 : sum[TOT_W-1:0];
                acc_d.flush = in_last;
            end else begin
                acc_d.open  = 1'b1;
                acc_d.flush = in_last;
                acc_d.win   = in_win;
                acc_d.total = TOT_W'(in_uops);
            end
        end else if (cause != CLS_NONE) begin
            acc_d.open  = 1'b0;
            acc_d.flush = 1'b0;
            acc_d.total = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign close_o       = (cause != CLS_NONE);
    assign close_win_o   = acc_q.win;
    assign close_total_o = acc_q.total;

    // R10: accumulating within one window never lowers the total
    p_total_grows_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && same) |=> (acc_q.total >= $past(acc_q.total)));

    // R4: a flushed window with no new input leaves nothing held
    p_flush_empties_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_q.flush && !in_valid) |=> !acc_q.open);
endmodule

// File: rtl/uc_way_alloc.sv
module uc_way_alloc #(
    parameter int NWAYS    = 3,
    parameter int WAY_UOPS = 6,
    parameter int TOT_W    = 8,
    parameter int DLV_W    = 6,
    parameter int WAYS_W   = 2,
    parameter int FILL_W   = 3,
    parameter int BEAT_W   = 3
) (
    input  logic [TOT_W-1:0]        total_i,
    output logic                    bypass_o,
    output logic [WAYS_W-1:0]       ways_o,
    output logic [NWAYS*FILL_W-1:0] fill_o,
    output logic [BEAT_W-1:0]       beats_o
);
    localparam int BUDGET = NWAYS * WAY_UOPS;
    localparam logic [TOT_W-1:0] BUDGET_T = TOT_W'(BUDGET);
    localparam logic [TOT_W-1:0] WAY_T    = TOT_W'(WAY_UOPS);

    logic [NWAYS-1:0] used;

    assign bypass_o = (total_i > BUDGET_T);

    for (genvar i = 0; i < NWAYS; i++) begin : g_way
        localparam logic [TOT_W-1:0] LO = TOT_W'(i * WAY_UOPS);
        logic [TOT_W-1:0] rest;
        always_comb begin
            rest = total_i - LO;
            if (bypass_o || total_i <= LO)
                fill_o[i*FILL_W +: FILL_W] = '0;
            else if (rest >= WAY_T)
                fill_o[i*FILL_W +: FILL_W] = FILL_W'(WAY_UOPS);
            else
                fill_o[i*FILL_W +: FILL_W] = FILL_W'(rest);
            used[i] = !bypass_o && (total_i > LO);
        end
    end

    always_comb begin
        ways_o = '0;
        for (int i = 0; i < NWAYS; i++)
            ways_o = ways_o + WAYS_W'(used[i]);
    end

    logic [TOT_W:0] beat_num;
    always_comb begin
        beat_num = {1'b0, total_i} + (TOT_W+1)'(DLV_W - 1);
        beats_o  = bypass_o ? '0 : BEAT_W'(beat_num / (TOT_W+1)'(DLV_W));
    end
endmodule

// File: rtl/uc_fill_track.sv
module uc_fill_track #(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 32,
    parameter int UOP_W     = 3,
    parameter int TOT_W     = 8,
    parameter int NWAYS     = 3,
    parameter int WAY_UOPS  = 6,
    parameter int DLV_W     = 6
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic [ADDR_W-1:0]                     in_addr,
    input  logic [UOP_W-1:0]                      in_uops,
    input  logic                                  in_last,
    output logic                                  rec_valid,
    output logic [ADDR_W-$clog2(WIN_BYTES)-1:0]   rec_window,
    output logic [TOT_W-1:0]                      rec_total,
    output logic                                  rec_bypass,
    output logic [$clog2(NWAYS+1)-1:0]            rec_ways,
    output logic [NWAYS*$clog2(WAY_UOPS+1)-1:0]   rec_fill,
    output logic [$clog2(NWAYS*WAY_UOPS/DLV_W+2)-1:0] rec_beats
);
    localparam int WIN_LSB = $clog2(WIN_BYTES);
    localparam int WIN_W   = ADDR_W - WIN_LSB;
    localparam int WAYS_W  = $clog2(NWAYS + 1);
    localparam int FILL_W  = $clog2(WAY_UOPS + 1);
    localparam int BUDGET  = NWAYS * WAY_UOPS;
    localparam int BEAT_W  = $clog2(BUDGET / DLV_W + 2);

    typedef struct packed {
        logic                    valid;
        logic [WIN_W-1:0]        win;
        logic [TOT_W-1:0]        total;
        logic                    bypass;
        logic [WAYS_W-1:0]       ways;
        logic [NWAYS*FILL_W-1:0] fill;
        logic [BEAT_W-1:0]       beats;
    } rec_t;

    rec_t out_d, out_q;

    logic                    close;
    logic [WIN_W-1:0]        close_win;
    logic [TOT_W-1:0]        close_total;
    logic                    a_bypass;
    logic [WAYS_W-1:0]       a_ways;
    logic [NWAYS*FILL_W-1:0] a_fill;
    logic [BEAT_W-1:0]       a_beats;
    logic                    unused_offset_bits;

    assign unused_offset_bits = ^in_addr[WIN_LSB-1:0];

    uc_window_acc #(.WIN_W(WIN_W), .UOP_W(UOP_W), .TOT_W(TOT_W)) i_acc (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_win       (in_addr[ADDR_W-1:WIN_LSB]),
        .in_uops      (in_uops),
        .in_last      (in_last),
        .close_o      (close),
        .close_win_o  (close_win),
        .close_total_o(close_total)
    );

    uc_way_alloc #(
        .NWAYS(NWAYS), .WAY_UOPS(WAY_UOPS), .TOT_W(TOT_W), .DLV_W(DLV_W),
        .WAYS_W(WAYS_W), .FILL_W(FILL_W), .BEAT_W(BEAT_W)
    ) i_alloc (
        .total_i (close_total),
        .bypass_o(a_bypass),
        .ways_o  (a_ways),
        .fill_o  (a_fill),
        .beats_o (a_beats)
    );

    always_comb begin
        out_d = '0;
        if (close) begin
            out_d.valid  = 1'b1;
            out_d.win    = close_win;
            out_d.total  = close_total;
            out_d.bypass = a_bypass;
            out_d.ways   = a_ways;
            out_d.fill   = a_fill;
            out_d.beats  = a_beats;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign rec_valid  = out_q.valid;
    assign rec_window = out_q.win;
    assign rec_total  = out_q.total;
    assign rec_bypass = out_q.bypass;
    assign rec_ways   = out_q.ways;
    assign rec_fill   = out_q.fill;
    assign rec_beats  = out_q.beats;

    // R5: never more ways than the budget allows
    p_ways_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_ways <= WAYS_W'(NWAYS)));

    // R5: a non-empty cacheable window always starts filling way 0
    p_first_way_r5: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_bypass && rec_total != '0) |-> (rec_fill[FILL_W-1:0] != '0));

    // R6: bypass only above budget, and then with no ways
    p_bypass_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_bypass) |-> (rec_total > TOT_W'(BUDGET) && rec_ways == '0));

    // R7: an uncached window needs no delivery cycles
    p_beats_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_bypass) |-> (rec_beats == '0));

    // R8: no record in the cycle after a reset edge
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> !rec_valid);
endmodule

// File: tb/test_uc_fill_track.sv
module test_uc_fill_track;
    localparam int DLV = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [2:0]  in_uops = '0;
    logic        in_last = 1'b0;
    logic        rec_valid;
    logic [26:0] rec_window;
    logic [7:0]  rec_total;
    logic        rec_bypass;
    logic [1:0]  rec_ways;
    logic [8:0]  rec_fill;
    logic [2:0]  rec_beats;

    uc_fill_track #(.DLV_W(DLV)) i_uc_fill_track (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_uops(in_uops), .in_last(in_last), .rec_valid(rec_valid),
        .rec_window(rec_window), .rec_total(rec_total), .rec_bypass(rec_bypass),
        .rec_ways(rec_ways), .rec_fill(rec_fill), .rec_beats(rec_beats)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Behavioural reference: one held window, closed on crossing or after last
    int m_open = 0, m_flush = 0, m_win = 0, m_total = 0;
    int e_valid = 0, e_win = 0, e_total = 0;

    always @(posedge clk) begin
        int w;
        w = int'(in_addr >> 5);
        if (rst) begin
            m_open = 0; m_flush = 0; m_total = 0; e_valid = 0;
        end else begin
            e_valid = (m_open != 0) && ((m_flush != 0) || (in_valid && w != m_win)) ? 1 : 0;
            if (e_valid != 0) begin
                e_win = m_win; e_total = m_total;
            end
            if (in_valid) begin
                if (m_open != 0 && m_flush == 0 && w == m_win) begin
                    m_total = m_total + int'(in_uops);
                    if (m_total > 255) m_total = 255;
                end else begin
                    m_open = 1; m_win = w; m_total = int'(in_uops);
                end
                m_flush = in_last ? 1 : 0;
            end else if (e_valid != 0) begin
                m_open = 0; m_flush = 0; m_total = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R9 rec_valid", int'(rec_valid), e_valid);
            if (e_valid != 0 && rec_valid) begin
                int t, byp;
                t   = e_total;
                byp = (t > 18) ? 1 : 0;
                chk("R1 rec_window", int'(rec_window), e_win);
                chk("R2 rec_total", int'(rec_total), t);
                chk("R6 rec_bypass", int'(rec_bypass), byp);
                chk("R5 rec_ways", int'(rec_ways), byp ? 0 : (t + 5) / 6);
                for (int i = 0; i < 3; i++) begin
                    int f;
                    f = (byp != 0 || t <= 6 * i) ? 0 : ((t - 6 * i >= 6) ? 6 : t - 6 * i);
                    chk("R5 rec_fill way", int'(rec_fill[i*3 +: 3]), f);
                end
                chk("R7 rec_beats", int'(rec_beats), byp ? 0 : (t + DLV - 1) / DLV);
            end else if (!rec_valid) begin
                chk("R9 idle fields", int'(rec_total) + int'(rec_ways) + int'(rec_bypass), 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    task automatic send(input int addr, input int uops, input bit last);
        in_valid = 1'b1;
        in_addr  = 32'(addr);
        in_uops  = 3'(uops);
        in_last  = last;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R8 reset state", int'(rec_valid), 0);

        // Four single-uop instructions, last flag
        send(32'h1000, 1, 0); send(32'h1001, 1, 0); send(32'h1002, 1, 0);
        send(32'h1003, 1, 1);
        chk("R4 no record one cycle after last", int'(rec_valid), 0);
        idle();
        chk("R4 record after last", int'(rec_valid), 1);
        chk("R2 single-uop total", int'(rec_total), 4);
        chk("R1 window index", int'(rec_window), 32'h1000 >> 5);
        idle();

        // Twelve instructions, the last one straddling into the next window
        for (int i = 0; i < 11; i++) send(32'h2000 + 2 * i, 1, 0);
        send(32'h201f, 1, 0);
        send(32'h2020, 3, 1);
        chk("R3 record on crossing", int'(rec_valid), 1);
        chk("R1 straddler charged to start window", int'(rec_total), 12);
        chk("R5 two ways for 12", int'(rec_ways), 2);
        idle();
        chk("R4 flushed new window", int'(rec_total), 3);
        idle();

        // Exactly at budget, then one over
        send(32'h4000, 6, 0); send(32'h4004, 6, 0); send(32'h4008, 6, 1);
        idle();
        chk("R6 budget 18 cacheable", int'(rec_bypass), 0);
        chk("R5 three full ways", int'(rec_fill), (6 << 6) | (6 << 3) | 6);
        send(32'h4020, 6, 0); send(32'h4024, 6, 0); send(32'h4028, 7, 1);
        idle();
        chk("R6 19 bypass", int'(rec_bypass), 1);
        chk("R6 bypass no ways", int'(rec_ways), 0);

        // Thirteen: partial third way
        send(32'h4800, 6, 0); send(32'h4804, 6, 0); send(32'h4808, 1, 1);
        idle();
        chk("R5 partial way fill", int'(rec_fill), (1 << 6) | (6 << 3) | 6);
        chk("R7 beats for 13", int'(rec_beats), 3);

        // Back-to-back crossing with last on each
        send(32'h5000, 2, 0); send(32'h5020, 2, 1); send(32'h5040, 1, 1);
        idle(); idle(); idle();

        // Saturation
        for (int i = 0; i < 40; i++) send(32'h3000, 7, (i == 39));
        idle();
        chk("R10 saturated total", int'(rec_total), 255);
        idle();

        // Reset discards a partial window
        send(32'h6000, 5, 0); send(32'h6004, 5, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 no record after reset", int'(rec_valid), 0);
        send(32'h7000, 2, 1);
        chk("R8 discarded window not emitted", int'(rec_valid), 0);
        idle();
        chk("R8 only new window total", int'(rec_total), 2);
        chk("R8 new window index", int'(rec_window), 32'h7000 >> 5);
        idle();

        // Random stream
        begin
            int a;
            a = 32'h8000;
            for (int i = 0; i < 600; i++) begin
                a = a + int'($urandom_range(1, 8));
                if ($urandom_range(0, 7) == 0) idle();
                send(a, int'($urandom_range(0, 4)), ($urandom_range(0, 15) == 0));
            end
        end
        idle(); idle(); idle();

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule